// File: doc/BRIEF.md
# Two-Queue Hit Field Splitter

The block sits between two hit queues and a histogram unit. Each queue holds 32-bit gatherer words tagged in their top nibble as header, hit or trailer. The block pulls words from the two queues in turn. It discards framing words and words with an unknown tag. For each hit it presents the pixel row, the column, a 3-bit chip identifier and a 4-bit time-over-threshold value, qualified by a one-cycle valid strobe.

The histogram unit paces the flow through a ready-for-data input. The block pops a queue word only in a cycle where that input is high. The queues are modelled as show-ahead synchronous read ports: the head word is visible while the queue is not empty, and a one-cycle pop request removes it at the next rising edge. The split fields appear on registered outputs in the cycle after the pop. Words with an unknown tag are counted on a saturating output counter.

Top module: `hit_extractor`

## Requirements
- R1: During and right after reset, `hit_valid` is 0, neither pop strobe is high while ready-for-data is low, and `drop_count` is 0.
- R2: While `hist_rfd` is 0, neither `src0_pop` nor `src1_pop` is asserted, whatever the queue state.
- R3: A pop strobe is never asserted for a queue whose empty flag is 1, and the two pop strobes are never high in the same cycle.
- R4: When both queues are non-empty and `hist_rfd` is 1, the queue not served by the most recent grant is popped, so grants alternate. The first such tie after reset goes to queue 0.
- R5: When `hist_rfd` is 1 and exactly one queue is non-empty, that queue is popped in the same cycle, with no idle cycle spent on the empty one.
- R6: Words tagged 4'b0010 (header) or 4'b0100 (trailer) in bits [31:28] produce no `hit_valid`.
- R7: A popped word tagged 4'b1000 (hit) gives `hit_valid`=1 in the next cycle, with `hit_row` = bits [8:0], `hit_col` = bits [15:9] and `hit_tot` = bits [23:20] (the upper nibble of the 8-bit field in bits [23:16]).
- R8: `hit_chip` equals {queue index, bits [25:24]} of the hit word, with queue 0 or 1 as the top bit.
- R9: A hit word whose bits [23:20] are 4'hF produces no `hit_valid` and does not change `drop_count`.
- R10: A popped word whose tag is none of the three codes produces no `hit_valid`. It raises `drop_count` by exactly one, and the count saturates at its maximum.
- R11: `hit_valid` is high only in the cycle right after a pop, and for one cycle per hit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src0_empty | input | 1 | Queue 0 has no word |
| src0_word | input | 32 | Head word of queue 0 (show-ahead) |
| src0_pop | output | 1 | Remove head word of queue 0 at this edge |
| src1_empty | input | 1 | Queue 1 has no word |
| src1_word | input | 32 | Head word of queue 1 (show-ahead) |
| src1_pop | output | 1 | Remove head word of queue 1 at this edge |
| hist_rfd | input | 1 | Histogram unit ready for data |
| hit_valid | output | 1 | Hit fields valid this cycle |
| hit_row | output | 9 | Pixel row |
| hit_col | output | 7 | Pixel column |
| hit_chip | output | 3 | Chip identifier |
| hit_tot | output | 4 | Time-over-threshold nibble |
| drop_count | output | CNT_W (16) | Saturating count of unknown-tag words |

## Verification
The assertions check the handshake on every cycle. No pop happens without ready-for-data or from an empty queue, and the two pops are never simultaneous. A tie goes to the other queue, and a lone non-empty queue is served at once. Every valid strobe traces back to a popped hit word with a non-0xF nibble, and the drop counter moves by one at a time. The values of the split fields, the chip mapping and the exact drop total can only be shown by the bench scenarios. These compare each output against a model of the queues: hits only, one queue empty, framing and unknown words, stalls and a random mix.

// File: rtl/hit_extractor_pkg.sv
// Shared word format for the hit extractor.
// Assumes the 32-bit gatherer word layout: tag [31:28], channel [25:24],
// 8-bit ToT [23:16], column [15:9], row [8:0].
package hit_extractor_pkg;

    localparam int WORD_W  = 32;
    localparam int ROW_W   = 9;
    localparam int COL_W   = 7;
    localparam int CH_W    = 2;
    localparam int TOT_W   = 4;
    localparam int NSRC    = 2;
    localparam int SRC_W   = 1;
    localparam int CHIP_W  = SRC_W + CH_W;

    localparam int TAG_LSB = 28;
    localparam int CH_LSB  = 24;
    localparam int TOT_LSB = 20;
    localparam int COL_LSB = 9;
    localparam int ROW_LSB = 0;

    localparam logic [TOT_W-1:0] TOT_NONE = '1;

    typedef enum logic [3:0] {
        TAG_HEAD = 4'b0010,
        TAG_HIT  = 4'b1000,
        TAG_TAIL = 4'b0100
    } word_tag_e;

    typedef struct packed {
        logic [CHIP_W-1:0] chip;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic [TOT_W-1:0]  tot;
    } hit_fields_t;

endpackage

// File: rtl/hx_rr_arbiter.sv
// Round-robin grant between the two queues.
// Assumes a request means "queue non-empty and consumer ready". A lone
// requester wins immediately; on a tie the queue not granted last wins.
module hx_rr_arbiter
    import hit_extractor_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] req,
    output logic [NSRC-1:0] gnt,
    output logic [SRC_W-1:0] gnt_idx
);
    logic [SRC_W-1:0] last_q;

    // Pick the winner for this cycle from the requests and the last grant.
    always_comb begin
        gnt     = '0;
        gnt_idx = '0;
        if (req[0] && req[1]) begin
            gnt_idx = ~last_q;
            gnt[gnt_idx] = 1'b1;
        end else if (req[0]) begin
            gnt_idx = 1'b0;
            gnt[0]  = 1'b1;
        end else if (req[1]) begin
            gnt_idx = 1'b1;
            gnt[1]  = 1'b1;
        end
    end

    // Remember the queue served by the latest grant; reset favours queue 0.
    always_ff @(posedge clk) begin
        if (!rst_n)
            last_q <= 1'b1;
        else if (|gnt)
            last_q <= gnt_idx;
    end

endmodule

// File: rtl/hx_word_decode.sv
// Combinational classification and field split of one granted word.
// Assumes the word is valid only when 'take' is high.
module hx_word_decode
    import hit_extractor_pkg::*;
(
    input  logic              take,
    input  logic [SRC_W-1:0]  src_idx,
    input  logic [WORD_W-1:0] word,
    output logic              emit_hit,
    output logic              bad_tag,
    output hit_fields_t       fields
);
    logic [3:0] tag;
    logic       is_hit;
    logic       is_frame;

    // Decode the tag nibble into hit, framing or unknown.
    always_comb begin
        tag      = word[TAG_LSB +: 4];
        is_hit   = (tag == TAG_HIT);
        is_frame = (tag == TAG_HEAD) || (tag == TAG_TAIL);
    end

    // Split the hit fields and decide whether a strobe is due.
    always_comb begin
        fields.chip = {src_idx, word[CH_LSB +: CH_W]};
        fields.row  = word[ROW_LSB +: ROW_W];
        fields.col  = word[COL_LSB +: COL_W];
        fields.tot  = word[TOT_LSB +: TOT_W];
        emit_hit    = take && is_hit && (fields.tot != TOT_NONE);
        bad_tag     = take && !is_hit && !is_frame;
    end

endmodule

// File: rtl/hx_out_stage.sv
// Output register for the hit fields and the saturating drop counter.
// Assumes at most one decoded word per cycle.
module hx_out_stage
    import hit_extractor_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             emit_hit,
    input  logic             bad_tag,
    input  hit_fields_t      fields_in,
    output logic             valid_q,
    output hit_fields_t      fields_q,
    output logic [CNT_W-1:0] drops_q
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Register the strobe and the fields of a hit popped this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q  <= 1'b0;
            fields_q <= '0;
        end else begin
            valid_q <= emit_hit;
            if (emit_hit)
                fields_q <= fields_in;
        end
    end

    // Count unknown-tag words, holding at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            drops_q <= '0;
        else if (bad_tag && drops_q != CNT_MAX)
            drops_q <= drops_q + 1'b1;
    end

endmodule

// File: rtl/hit_extractor.sv
// Top: drains two show-ahead queues in round-robin order while the
// histogram unit is ready, drops framing and unknown words, and presents
// hits as split fields one cycle after the pop.
// Assumes the queues remove their head word on an edge where pop is high.
module hit_extractor
    import hit_extractor_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src0_empty,
    input  logic [31:0]      src0_word,
    output logic             src0_pop,
    input  logic             src1_empty,
    input  logic [31:0]      src1_word,
    output logic             src1_pop,
    input  logic             hist_rfd,
    output logic             hit_valid,
    output logic [8:0]       hit_row,
    output logic [6:0]       hit_col,
    output logic [2:0]       hit_chip,
    output logic [3:0]       hit_tot,
    output logic [CNT_W-1:0] drop_count
);
    logic [NSRC-1:0]   empty_v;
    logic [WORD_W-1:0] word_v [NSRC];
    logic [NSRC-1:0]   req;
    logic [NSRC-1:0]   gnt;
    logic [SRC_W-1:0]  gnt_idx;
    logic              emit_hit;
    logic              bad_tag;
    hit_fields_t       dec_fields;
    hit_fields_t       out_fields;

    assign empty_v   = {src1_empty, src0_empty};
    assign word_v[0] = src0_word;
    assign word_v[1] = src1_word;

    // One request per queue: it has a word and the consumer is ready.
    for (genvar s = 0; s < NSRC; s++) begin : g_req
        assign req[s] = hist_rfd && !empty_v[s];
    end

    hx_rr_arbiter u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req),
        .gnt     (gnt),
        .gnt_idx (gnt_idx)
    );

    assign src0_pop = gnt[0];
    assign src1_pop = gnt[1];

    hx_word_decode u_dec (
        .take     (|gnt),
        .src_idx  (gnt_idx),
        .word     (word_v[gnt_idx]),
        .emit_hit (emit_hit),
        .bad_tag  (bad_tag),
        .fields   (dec_fields)
    );

    hx_out_stage #(.CNT_W(CNT_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .emit_hit  (emit_hit),
        .bad_tag   (bad_tag),
        .fields_in (dec_fields),
        .valid_q   (hit_valid),
        .fields_q  (out_fields),
        .drops_q   (drop_count)
    );

    assign hit_row  = out_fields.row;
    assign hit_col  = out_fields.col;
    assign hit_chip = out_fields.chip;
    assign hit_tot  = out_fields.tot;

endmodule

// File: rtl/hit_extractor_checker.sv
// Port-level protocol checks for hit_extractor, attached by bind.
module hit_extractor_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             src0_empty,
    input logic [31:0]      src0_word,
    input logic             src0_pop,
    input logic             src1_empty,
    input logic [31:0]      src1_word,
    input logic             src1_pop,
    input logic             hist_rfd,
    input logic             hit_valid,
    input logic [CNT_W-1:0] drop_count
);
    logic [31:0] taken_word;
    assign taken_word = src0_pop ? src0_word : src1_word;

    // R2: no pop without ready-for-data
    p_no_pop_stalled_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !hist_rfd |-> (!src0_pop && !src1_pop));

    // R3: never pop an empty queue, never pop both
    p_no_empty_pop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !((src0_pop && src0_empty) || (src1_pop && src1_empty)));
    p_single_pop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(src0_pop && src1_pop));

    // R4: on a tie, the other queue follows a grant
    p_alternate_after0_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_rfd && !src0_empty && !src1_empty && $past(src0_pop)) |-> src1_pop);
    p_alternate_after1_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_rfd && !src0_empty && !src1_empty && $past(src1_pop)) |-> src0_pop);

    // R5: a lone non-empty queue is served at once
    p_skip_empty0_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_rfd && src0_empty && !src1_empty) |-> src1_pop);
    p_skip_empty1_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_rfd && !src0_empty && src1_empty) |-> src0_pop);

    // R11: a strobe follows a pop
    p_valid_after_pop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid |-> $past(src0_pop || src1_pop));

    // R6 and R9: the strobe comes only from a hit word with a usable nibble
    p_valid_only_hits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid |-> ($past(taken_word[31:28]) == 4'b1000
                       && $past(taken_word[23:20]) != 4'hF));

    // R10: the drop count moves by one at most, upward
    p_drop_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_count != $past(drop_count)) |->
            ((drop_count - $past(drop_count)) == CNT_W'(1)));

endmodule

bind hit_extractor hit_extractor_checker #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .src0_empty (src0_empty),
    .src0_word  (src0_word),
    .src0_pop   (src0_pop),
    .src1_empty (src1_empty),
    .src1_word  (src1_word),
    .src1_pop   (src1_pop),
    .hist_rfd   (hist_rfd),
    .hit_valid  (hit_valid),
    .drop_count (drop_count)
);

// File: tb/hit_extractor_tb_top.sv
module hit_extractor_tb_top;
    localparam int CNT_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic src0_empty = 1'b1, src1_empty = 1'b1;
    logic [31:0] src0_word = '0, src1_word = '0;
    logic src0_pop, src1_pop;
    logic hist_rfd = 1'b0;
    logic hit_valid;
    logic [8:0] hit_row;
    logic [6:0] hit_col;
    logic [2:0] hit_chip;
    logic [3:0] hit_tot;
    logic [CNT_W-1:0] drop_count;

    always #10 clk = ~clk;

    hit_extractor #(.CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .src0_empty(src0_empty), .src0_word(src0_word), .src0_pop(src0_pop),
        .src1_empty(src1_empty), .src1_word(src1_word), .src1_pop(src1_pop),
        .hist_rfd(hist_rfd), .hit_valid(hit_valid), .hit_row(hit_row),
        .hit_col(hit_col), .hit_chip(hit_chip), .hit_tot(hit_tot),
        .drop_count(drop_count)
    );

    int checks = 0;
    int errs = 0;
    logic [31:0] q0[$];
    logic [31:0] q1[$];
    int grant = -1;
    int exp_last = 1;
    int exp_drops = 0;
    int rfd_pct = 100;
    int hits_seen = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [3:0] tag, input logic [1:0] ch,
                                       input logic [7:0] tot, input logic [6:0] col,
                                       input logic [8:0] row);
        return {tag, 2'b00, ch, tot, col, row};
    endfunction

    function automatic logic [31:0] rnd_word();
        int k = $urandom_range(9);
        logic [3:0] tag;
        if (k < 6) tag = 4'b1000;
        else if (k == 6) tag = 4'b0010;
        else if (k == 7) tag = 4'b0100;
        else begin
            tag = 4'($urandom_range(15));
            if (tag == 4'b1000 || tag == 4'b0010 || tag == 4'b0100) tag = 4'hC;
        end
        return mk(tag, 2'($urandom), 8'($urandom), 7'($urandom), 9'($urandom));
    endfunction

    // One bench cycle: retire last grant, check outputs, drive, check pops.
    task automatic step();
        logic [31:0] w;
        bit ev = 0;
        logic [2:0] e_chip = '0;
        logic [8:0] e_row = '0;
        logic [6:0] e_col = '0;
        logic [3:0] e_tot = '0;
        bit e0, e1, x0, x1;
        @(negedge clk);
        if (grant >= 0) begin
            w = (grant == 0) ? q0.pop_front() : q1.pop_front();
            if (w[31:28] == 4'b1000 && w[23:20] != 4'hF) begin
                ev = 1;
                e_chip = {grant[0], w[25:24]};
                e_row = w[8:0]; e_col = w[15:9]; e_tot = w[23:20];
            end else if (w[31:28] != 4'b1000 && w[31:28] != 4'b0010
                         && w[31:28] != 4'b0100) begin
                exp_drops++;
            end
        end
        // R6 R9 R10 R11: strobe only for usable hits, right after the pop
        chk(hit_valid == ev, "R11", "hit_valid", int'(hit_valid), int'(ev));
        if (ev && hit_valid) begin
            hits_seen++;
            chk(hit_row == e_row, "R7", "row", int'(hit_row), int'(e_row));
            chk(hit_col == e_col, "R7", "col", int'(hit_col), int'(e_col));
            chk(hit_tot == e_tot, "R7", "tot", int'(hit_tot), int'(e_tot));
            chk(hit_chip == e_chip, "R8", "chip", int'(hit_chip), int'(e_chip));
        end
        hist_rfd   = ($urandom_range(99) < rfd_pct);
        src0_empty = (q0.size() == 0);
        src1_empty = (q1.size() == 0);
        src0_word  = src0_empty ? 32'($urandom) : q0[0];
        src1_word  = src1_empty ? 32'($urandom) : q1[0];
        #1;
        e0 = !src0_empty; e1 = !src1_empty;
        x0 = 0; x1 = 0;
        if (hist_rfd) begin
            if (e0 && e1) begin
                if (exp_last == 1) x0 = 1; else x1 = 1;
            end else begin
                x0 = e0; x1 = e1;
            end
        end
        if (!hist_rfd)
            chk(!src0_pop && !src1_pop, "R2", "pop while stalled",
                int'({src1_pop, src0_pop}), 0);
        else if (e0 && e1)
            chk(src0_pop == x0 && src1_pop == x1, "R4", "tie grant",
                int'({src1_pop, src0_pop}), int'({x1, x0}));
        else
            chk(src0_pop == x0 && src1_pop == x1, "R5", "lone grant",
                int'({src1_pop, src0_pop}), int'({x1, x0}));
        if (x0) exp_last = 0;
        if (x1) exp_last = 1;
        if (src0_pop && !src0_empty) grant = 0;
        else if (src1_pop && !src1_empty) grant = 1;
        else grant = -1;
    endtask

    task automatic drain(input string req);
        int n = 0;
        while ((q0.size() != 0 || q1.size() != 0 || grant >= 0) && n < 20000) begin
            step();
            n++;
        end
        step();
        chk(q0.size() == 0 && q1.size() == 0, req, "queues drained",
            q0.size() + q1.size(), 0);
        // R10: drop count matches unknown words seen
        chk(int'(drop_count) == exp_drops, "R10", "drop_count",
            int'(drop_count), exp_drops);
    endtask

    initial begin : watchdog
        #3000000;
        if (!finished) begin
            errs++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errs);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(hit_valid == 0, "R1", "hit_valid in reset", int'(hit_valid), 0);
        chk(drop_count == 0, "R1", "drop_count in reset", int'(drop_count), 0);
        chk(!src0_pop && !src1_pop, "R1", "pops in reset",
            int'({src1_pop, src0_pop}), 0);
        rst_n = 1'b1;

        // R5: only queue 1 holds words
        rfd_pct = 100;
        for (int i = 0; i < 8; i++)
            q1.push_back(mk(4'b1000, 2'(i), 8'(i * 16), 7'(i + 3), 9'(i * 40)));
        drain("R5");

        // R4: both queues full of hits, always ready
        for (int i = 0; i < 10; i++) begin
            q0.push_back(mk(4'b1000, 2'(i), 8'h52, 7'(i), 9'(300 + i)));
            q1.push_back(mk(4'b1000, 2'(3 - i % 4), 8'hE1, 7'(100 + i), 9'(i)));
        end
        drain("R4");

        // R2: stalled with words waiting, then released
        for (int i = 0; i < 4; i++) begin
            q0.push_back(mk(4'b1000, 2'd1, 8'h30, 7'd5, 9'd7));
            q1.push_back(mk(4'b1000, 2'd2, 8'h40, 7'd6, 9'd8));
        end
        rfd_pct = 0;
        repeat (20) step();
        chk(q0.size() == 4 && q1.size() == 4, "R2", "no words moved",
            q0.size() + q1.size(), 8);
        rfd_pct = 100;
        drain("R2");

        // R6 R9 R10: framing, no-hit nibble, unknown tags, edge field values
        q0.push_back(mk(4'b0010, 2'd0, 8'h00, 7'h00, 9'h000));
        q0.push_back(mk(4'b1000, 2'd3, 8'hF0, 7'h7F, 9'h1FF));
        q0.push_back(mk(4'b1000, 2'd3, 8'hEF, 7'h7F, 9'h1FF));
        q0.push_back(mk(4'b0100, 2'd0, 8'h00, 7'h00, 9'h000));
        q1.push_back(mk(4'b1111, 2'd1, 8'h10, 7'h01, 9'h001));
        q1.push_back(mk(4'b0000, 2'd1, 8'h10, 7'h01, 9'h001));
        q1.push_back(mk(4'b1000, 2'd0, 8'h0F, 7'h00, 9'h000));
        q1.push_back(mk(4'b0010, 2'd2, 8'h22, 7'h02, 9'h002));
        drain("R6");

        // R7 R8: random mix with random back-pressure
        rfd_pct = 70;
        for (int i = 0; i < 400; i++) begin
            if ($urandom_range(1)) q0.push_back(rnd_word());
            else q1.push_back(rnd_word());
        end
        drain("R7");
        chk(hits_seen > 100, "R7", "hits observed", hits_seen, 100);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    end

endmodule